// File: doc/BRIEF.md
# Signed-Amount Rotate and Shift Unit

This block moves a 16-bit data word by a signed distance in one combinational pass. A positive distance moves the word toward the most significant end and a negative distance moves it toward the least significant end. A two-bit selector picks circular rotation, logical shift, arithmetic shift or a pass-through. It is intended to sit inside a datapath, for example the execute stage of a small processor, where the shift distance arrives as a signed field.

One right-rotating network does every job. It is built as a chain of log2(N) stages of 2:1 multiplexers. A move toward the most significant end by k is rewritten as a right rotation by N−k. After the rotation, a fill stage overwrites the bit positions that wrapped around. The fill value is zero, or the original sign bit for an arithmetic move toward the least significant end. The block holds no clock and no storage.

Top module: `barrel_rotmask`

## Requirements
- R1: `amount` is a 5-bit two's complement value in −16..15. A positive value moves data toward bit 15 (left) and a negative value moves it toward bit 0 (right).
- R2: With `mode` = 2'b00 (rotate), `dout` is `din` rotated left by `amount` when it is positive and rotated right by −`amount` when it is negative. −16 is taken modulo 16 and returns `din`.
- R3: With `mode` = 2'b01 (logical) and `amount` = k > 0, `dout[i]` = `din[i−k]` for i ≥ k, and the lowest k bits are 0.
- R4: With `mode` = 2'b01 and `amount` = −k in −15..−1, `dout[i]` = `din[i+k]` for i < 16−k, and the top k bits are 0.
- R5: With `mode` = 2'b10 (arithmetic) and `amount` = −k in −15..−1, the result is the R4 result, except that the top k bits equal `din[15]`.
- R6: With `mode` = 2'b10 and a positive `amount`, `dout` equals the logical left result of R3.
- R7: With `amount` = 0, `dout` equals `din` in every mode.
- R8: In modes 2'b01 and 2'b10, `amount` = −16 acts as a right shift by 15.
- R9: With `mode` = 2'b11, `dout` equals `din` for any `amount`.
- R10: `dout` follows a change on any input without a clock edge.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| din | input | 16 | Data word to move |
| amount | input | 5 | Signed distance: positive means left, negative means right |
| mode | input | 2 | 00 rotate, 01 logical, 10 arithmetic, 11 pass-through |
| dout | output | 16 | Moved word |

## Verification
The assertions assume that the inputs are settled when they are evaluated. They also assume the data width is a power of two, so that the rotation count wraps cleanly and the fill count for a shift matches the clamped distance. The stimulus changes inputs only between checks. It sweeps every distance from −16 to 15 in every mode, over data patterns that include an all-zero word, an all-ones word, a single set sign bit and mixed words. This covers both sign-fill values and both ends of the distance range. A direct input change with no clock edge between it and the check covers the purely combinational timing.

// File: rtl/rsh_pkg.sv
// Package: shared mode encoding for the rotate-and-mask shifter.
// Assumes the two-bit mode field is decoded exactly as listed.
package rsh_pkg;
    typedef enum logic [1:0] {
        MODE_ROT  = 2'b00,
        MODE_LOG  = 2'b01,
        MODE_ARI  = 2'b10,
        MODE_PASS = 2'b11
    } rsh_mode_e;
endpackage

// File: rtl/rsh_amount_conv.sv
// Module: turns a signed distance into a right-rotation count and a fill
// count. Assumes WIDTH is a power of two, so an SHW-bit count wraps modulo
// WIDTH. For shifts the magnitude is clamped to WIDTH-1. For rotates it is
// taken modulo WIDTH.
module rsh_amount_conv #(
    parameter int WIDTH = 16,
    localparam int SHW = $clog2(WIDTH),
    localparam int AW  = SHW + 1
) (
    input  logic [AW-1:0]  amt,
    input  logic           is_rot,
    output logic [SHW-1:0] rot_cnt,
    output logic [SHW-1:0] fill_cnt,
    output logic           go_left
);
    logic [AW-1:0]  mag_full;
    logic [SHW-1:0] clamp_mag;
    logic [SHW-1:0] eff_mag;

    // Purpose: magnitude, direction, clamp and the equivalent right rotation.
    always_comb begin
        go_left   = ~amt[AW-1] && (amt != '0);
        mag_full  = amt[AW-1] ? (~amt + 1'b1) : amt;
        clamp_mag = mag_full[AW-1] ? SHW'(WIDTH - 1) : mag_full[SHW-1:0];
        eff_mag   = is_rot ? mag_full[SHW-1:0] : clamp_mag;
        rot_cnt   = go_left ? (SHW'(0) - eff_mag) : eff_mag;
        fill_cnt  = is_rot ? '0 : clamp_mag;
    end
endmodule

// File: rtl/rsh_rotator.sv
// Module: right rotator made of SHW stages of 2:1 multiplexers. Stage k
// rotates right by 2**k when bit k of the count is set. Assumes WIDTH is a
// power of two.
module rsh_rotator #(
    parameter int WIDTH = 16,
    localparam int SHW = $clog2(WIDTH)
) (
    input  logic [WIDTH-1:0] din,
    input  logic [SHW-1:0]   cnt,
    output logic [WIDTH-1:0] dout
);
    logic [WIDTH-1:0] stage_w [0:SHW];

    assign stage_w[0] = din;

    for (genvar k = 0; k < SHW; k++) begin : g_stage
        localparam int STEP = 1 << k;
        for (genvar i = 0; i < WIDTH; i++) begin : g_bit
            // Purpose: pick the bit STEP positions up, or keep this one.
            assign stage_w[k+1][i] = cnt[k] ? stage_w[k][(i + STEP) % WIDTH]
                                            : stage_w[k][i];
        end
    end

    assign dout = stage_w[SHW];
endmodule

// File: rtl/rsh_mask.sv
// Module: overwrites the wrapped positions of the rotated word. A right
// shift fills the top fill_cnt bits. A left shift fills the bottom fill_cnt
// bits. An arithmetic right shift fills with the original sign bit, and
// every other fill is zero. Rotate leaves the word alone, and pass-through
// returns the original input.
module rsh_mask #(
    parameter int WIDTH = 16,
    localparam int SHW = $clog2(WIDTH)
) (
    input  logic [WIDTH-1:0] din,
    input  logic [WIDTH-1:0] rot_w,
    input  logic [SHW-1:0]   fill_cnt,
    input  logic             go_left,
    input  rsh_pkg::rsh_mode_e mode,
    output logic [WIDTH-1:0] fill_mask,
    output logic [WIDTH-1:0] dout
);
    import rsh_pkg::*;

    logic is_shift;
    logic fill_val;

    // Purpose: decide whether any fill applies and which value it uses.
    always_comb begin
        is_shift = (mode == MODE_LOG) || (mode == MODE_ARI);
        fill_val = (mode == MODE_ARI) && !go_left && din[WIDTH-1];
    end

    for (genvar i = 0; i < WIDTH; i++) begin : g_mask
        localparam int HI_LIM = WIDTH - 1 - i;
        // Purpose: mark bit i when it falls inside the wrapped span.
        assign fill_mask[i] = is_shift &&
            (go_left ? (int'(fill_cnt) > i) : (int'(fill_cnt) > HI_LIM));
    end

    // Purpose: choose the pass-through word, the fill value or the rotated bit.
    always_comb begin
        for (int i = 0; i < WIDTH; i++) begin
            dout[i] = fill_mask[i] ? fill_val : rot_w[i];
        end
        if (mode == MODE_PASS) dout = din;
    end
endmodule

// File: rtl/barrel_rotmask.sv
// Module: top of the signed-amount rotate/shift unit. It is purely
// combinational. A distance converter feeds a single right rotator, and a
// fill stage follows. Assumes WIDTH is a power of two.
module barrel_rotmask #(
    parameter int WIDTH = 16,
    localparam int SHW = $clog2(WIDTH),
    localparam int AW  = SHW + 1
) (
    input  logic [WIDTH-1:0] din,
    input  logic [AW-1:0]    amount,
    input  logic [1:0]       mode,
    output logic [WIDTH-1:0] dout
);
    import rsh_pkg::*;

    rsh_mode_e        mode_e;
    logic [SHW-1:0]   rot_cnt;
    logic [SHW-1:0]   fill_cnt;
    logic             go_left;
    logic [WIDTH-1:0] rot_w;
    logic [WIDTH-1:0] fill_mask;

    assign mode_e = rsh_mode_e'(mode);

    rsh_amount_conv #(.WIDTH(WIDTH)) u_conv (
        .amt     (amount),
        .is_rot  (mode_e == MODE_ROT),
        .rot_cnt (rot_cnt),
        .fill_cnt(fill_cnt),
        .go_left (go_left)
    );

    rsh_rotator #(.WIDTH(WIDTH)) u_rot (
        .din (din),
        .cnt (rot_cnt),
        .dout(rot_w)
    );

    rsh_mask #(.WIDTH(WIDTH)) u_mask (
        .din      (din),
        .rot_w    (rot_w),
        .fill_cnt (fill_cnt),
        .go_left  (go_left),
        .mode     (mode_e),
        .fill_mask(fill_mask),
        .dout     (dout)
    );
endmodule

// File: rtl/rsh_checker.sv
// Module: assertion checker bound to barrel_rotmask. It uses immediate
// checks on settled combinational values, because the block has no clock.
module rsh_checker #(
    parameter int WIDTH = 16,
    localparam int SHW = $clog2(WIDTH),
    localparam int AW  = SHW + 1
) (
    input logic [WIDTH-1:0] din,
    input logic [AW-1:0]    amount,
    input logic [1:0]       mode,
    input logic [WIDTH-1:0] dout,
    input logic [WIDTH-1:0] fill_mask
);
    int exp_fill;

    // Purpose: relate the port values to the fill span and to the output.
    always_comb begin
        exp_fill = 0;
        if (mode == 2'b01 || mode == 2'b10) begin
            exp_fill = $signed(amount) < 0 ? -$signed(amount) : $signed(amount);
            if (exp_fill > WIDTH - 1) exp_fill = WIDTH - 1;
        end
        AST_ZERO_IDENTITY: assert (amount != '0 || dout == din) else $error("zero distance"); // R7
        AST_PASS_MODE: assert (mode != 2'b11 || dout == din) else $error("pass mode"); // R9
        AST_ROT_KEEPS_ONES: assert (mode != 2'b00 || $countones(dout) == $countones(din)) else $error("rotate ones"); // R2
        AST_FILL_SPAN: assert ($countones(fill_mask) == exp_fill) else $error("fill span"); // R3
        AST_LOG_NO_NEW_ONES: assert (mode != 2'b01 || $countones(dout) <= $countones(din)) else $error("logical ones"); // R4
        AST_ARI_SIGN_KEPT: assert (!(mode == 2'b10 && amount[AW-1]) || dout[WIDTH-1] == din[WIDTH-1]) else $error("sign fill"); // R5
    end
endmodule

bind barrel_rotmask rsh_checker #(.WIDTH(WIDTH)) u_rsh_checker (
    .din      (din),
    .amount   (amount),
    .mode     (mode),
    .dout     (dout),
    .fill_mask(fill_mask)
);

// File: tb/test_barrel_rotmask.sv
// Bench: behavioural reference model compared against the output on every clock.
module test_barrel_rotmask;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [15:0] din = '0;
    logic [4:0]  amount = '0;
    logic [1:0]  mode = '0;
    logic [15:0] dout;
    int total = 0;
    int bad = 0;
    int cycles = 0;
    bit done = 0;

    always #5 clk = ~clk;

    barrel_rotmask i_barrel_rotmask (
        .din(din), .amount(amount), .mode(mode), .dout(dout)
    );

    function automatic logic [15:0] ref_model(logic [15:0] d, int a, int m);
        logic [15:0] r;
        int mag;
        int rl;
        r = '0;
        if (m == 3 || a == 0) return d;
        if (m == 0) begin
            rl = ((a % 16) + 16) % 16;
            for (int i = 0; i < 16; i++) r[(i + rl) % 16] = d[i];
            return r;
        end
        mag = (a < 0) ? -a : a;
        if (mag > 15) mag = 15;
        for (int i = 0; i < 16; i++) begin
            if (a > 0) r[i] = (i >= mag) ? d[i - mag] : 1'b0;
            else       r[i] = (i + mag < 16) ? d[i + mag] : ((m == 2) ? d[15] : 1'b0);
        end
        return r;
    endfunction

    function automatic string req_of(int a, int m);
        if (m == 3) return "R9";
        if (a == 0) return "R7";
        if (m == 0) return "R2";
        if (a == -16) return "R8";
        if (m == 2) return (a > 0) ? "R6" : "R5";
        return (a > 0) ? "R3" : "R4";
    endfunction

    task automatic check(string req, logic [15:0] act, logic [15:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s: actual=%h expected=%h (din=%h amount=%0d mode=%0d)",
                     req, act, exp, din, $signed(amount), mode);
        end
    endtask

    task automatic apply(logic [15:0] d, int a, int m);
        @(negedge clk);
        din = d; amount = 5'(a); mode = 2'(m);
        #1;
        check(req_of(a, m), dout, ref_model(d, a, m));
    endtask

    always @(posedge clk) begin
        cycles++;
        if (cycles > 100000 && !done) begin
            done = 1;
            bad++; total++;
            $display("FAIL watchdog: actual=timeout expected=finish");
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin
        logic [15:0] pats [6];
        pats = '{16'h0000, 16'hFFFF, 16'h8000, 16'h0001, 16'hA5C3, 16'h7E18};
        repeat (3) @(posedge clk);
        rst_n = 1'b1;
        #1;
        check("R7", dout, 16'h0000);            // initial idle inputs give zero
        apply(16'h0001, 3, 1);
        check("R1", dout, 16'h0008);            // positive distance moves left
        apply(16'h8000, -3, 1);
        check("R1", dout, 16'h1000);            // negative distance moves right
        apply(16'h8421, -16, 0);
        check("R2", dout, 16'h8421);            // rotate by -16 is identity
        apply(16'h8001, -16, 2);
        check("R8", dout, 16'hFFFF);            // clamped to 15, sign filled
        apply(16'h1234, 5, 3);
        check("R9", dout, 16'h1234);
        din = 16'h00F0; amount = 5'(4); mode = 2'b00;
        #1;
        check("R10", dout, 16'h0F00);           // no clock edge in between
        din = 16'h00F0; amount = 5'(-4);
        #1;
        check("R10", dout, 16'h000F);
        foreach (pats[p])
            for (int a = -16; a < 16; a++)
                for (int m = 0; m < 4; m++)
                    apply(pats[p], a, m);
        done = 1;
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule